// File: doc/BRIEF.md
# Masked Event Interrupt Unit

This block collects the interrupt-worthy events of a network controller into one 32-bit event register and pairs it with a 32-bit mask register. Thirteen event bits are implemented at fixed positions in the upper part of the word. Each has its own level interrupt line, and the line is driven high while both the event bit and the matching mask bit are set. The event sources raise bits with one-cycle pulses. Software clears a bit by writing a one to it in the event register and loads the mask with a plain write.

Two pulses have a fixed source inside the controller. A write to the management frame register raises the management-done event. A write to the transmit control register with its stop request set raises the graceful-stop event in the same cycle. A soft reset, driven by the controller's own reset control bit, clears both registers. Reads are combinational on a single select line.

Top module: `evt_irq_unit`

## Requirements
- R1: After the reset input rises, the event register, the mask register and all 13 interrupt lines are zero.
- R2: Pulse line i of `evt_pulse` (i = 0 to 12) sets event bit 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 respectively, and the bit can be read back in the next cycle.
- R3: A write with `reg_sel` = 0 clears every event bit that is 1 in `reg_wdata` and leaves all other event bits unchanged. With no write and no pulse, the event register holds its value.
- R4: When a set pulse and a one-to-clear write hit the same event bit in the same cycle, the bit is set afterwards.
- R5: A write with `reg_sel` = 1 replaces all 32 mask bits with `reg_wdata`, and a read with `reg_sel` = 1 returns them.
- R6: `irq_o[i]` is high exactly when the event bit of line i (position as in R2) and the mask bit at the same position are both set. The line changes one clock cycle after the register bit that causes the change.
- R7: Event bits 18 to 0 always read as zero, whatever is written or pulsed.
- R8: `mgmt_wr` sets event bit 23 (line 6).
- R9: `txctl_wr` together with `txctl_go` sets event bit 28 (line 9). `txctl_wr` with `txctl_go` low changes nothing.
- R10: `soft_rst` clears the event and mask registers, and it takes precedence over set pulses and register writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Controller reset pulse that clears both registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 event, 1 mask |
| reg_wdata | input | 32 | Write data (ones-to-clear for the event register) |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 13 | One-cycle set pulses, indexed by interrupt line |
| mgmt_wr | input | 1 | Management frame register write (sets management-done) |
| txctl_wr | input | 1 | Transmit control register write |
| txctl_go | input | 1 | Stop request bit of that write (sets graceful-stop) |
| irq_o | output | 13 | Level interrupt lines |

## Verification
The assertions check on every cycle that a pulsed bit is present after the edge, that a cleared bit without a pulse is gone, and that the event register holds when nothing touches it. They also check that a mask write lands whole, that a soft reset empties both registers, that the reserved bits read zero, and that a line masked off falls low two cycles later. The bit position of each line, the order of outputs against positions, the one-cycle lag of each line, and the no-effect case of a stop-less transmit control write are shown only by the bench's directed scenarios, which read the registers back and watch the lines.

// File: rtl/evt_irq_unit.sv
module evt_irq_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [12:0] evt_pulse,
  input  logic        mgmt_wr,
  input  logic        txctl_wr,
  input  logic        txctl_go,
  output logic [12:0] irq_o
);

  localparam int          NLINE   = 13;
  localparam logic [31:0] EV_IMPL = 32'hFFF8_0000;

  function automatic int line_pos(input int i);
    case (i)
      0: return 27;  1: return 26;  2: return 19;  3: return 20;
      4: return 25;  5: return 24;  6: return 23;  7: return 21;
      8: return 31;  9: return 28; 10: return 22; 11: return 29;
      default: return 30;
    endcase
  endfunction

  logic [31:0]      ev_q, mask_q, set_vec, clr_vec;
  logic [NLINE-1:0] pulse_eff, irq_q;

  assign pulse_eff = evt_pulse | {3'b0, txctl_wr & txctl_go, 2'b0, mgmt_wr, 6'b0};
  assign clr_vec   = (reg_wr && !reg_sel) ? reg_wdata : '0;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NLINE; i++) set_vec[line_pos(i)] = pulse_eff[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= ((ev_q & ~clr_vec) | set_vec) & EV_IMPL;
      if (reg_wr && reg_sel) mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else for (int i = 0; i < NLINE; i++)
      irq_q[i] <= ev_q[line_pos(i)] & mask_q[line_pos(i)];
  end

  assign irq_o     = irq_q;
  assign reg_rdata = reg_sel ? mask_q : ev_q;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && set_vec != '0) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> ((ev_q & $past(reg_wdata & ~set_vec)) == '0));

  assert_ev_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(reg_wr && !reg_sel) && set_vec == '0) |=> $stable(ev_q));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !soft_rst) |=> (mask_q == $past(reg_wdata)));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ev_q == '0 && mask_q == '0));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & ~EV_IMPL) == '0));

  for (genvar g = 0; g < NLINE; g++) begin : g_line_chk
    localparam int P = line_pos(g);
    assert_masked_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && !reg_wdata[P]) |=> ##1 !irq_o[g]);
  end

endmodule

// File: tb/evt_irq_unit_tb_top.sv
`timescale 1ns/1ps
module evt_irq_unit_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        soft_rst = 0, reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [12:0] evt_pulse = '0, irq_o;
  logic        mgmt_wr = 0, txctl_wr = 0, txctl_go = 0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int pos [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
  logic [31:0] m_ev = '0, m_mask = '0;

  always #2.5 clk = ~clk;

  evt_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .mgmt_wr(mgmt_wr), .txctl_wr(txctl_wr),
    .txctl_go(txctl_go), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [12:0] p, input bit wr, input bit sel, input logic [31:0] wd,
                    input bit mg, input bit tx, input bit go, input bit sr);
    logic [31:0] sv;
    @(negedge clk);
    evt_pulse = p; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    mgmt_wr = mg; txctl_wr = tx; txctl_go = go; soft_rst = sr;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 0; reg_wdata = '0; mgmt_wr = 0; txctl_wr = 0; txctl_go = 0; soft_rst = 0;
    sv = '0;
    for (int i = 0; i < 13; i++) if (p[i]) sv[pos[i]] = 1'b1;
    if (mg) sv[23] = 1'b1;
    if (tx && go) sv[28] = 1'b1;
    if (sr) begin m_ev = '0; m_mask = '0; end
    else begin
      if (wr && !sel) m_ev = m_ev & ~wd;
      m_ev = (m_ev | sv) & 32'hFFF8_0000;
      if (wr && sel) m_mask = wd;
    end
  endtask

  task automatic check_regs(input string tag);
    reg_sel = 0; #0.5; chk({tag, " event"}, reg_rdata, m_ev);
    reg_sel = 1; #0.5; chk({tag, " mask"}, reg_rdata, m_mask);
  endtask

  function automatic logic [31:0] exp_irq();
    logic [31:0] e = '0;
    for (int i = 0; i < 13; i++) e[i] = m_ev[pos[i]] & m_mask[pos[i]];
    return e;
  endfunction

  task automatic check_irq(input string tag);
    @(negedge clk);
    chk({tag, " irq"}, {19'b0, irq_o}, exp_irq());
  endtask

  task automatic clear_all();
    op('0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    op('0, 1, 1, 32'h0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    check_regs("R1 reset");
    chk("R1 reset irq", {19'b0, irq_o}, 32'h0);
  endtask

  task automatic t_positions();
    for (int i = 0; i < 13; i++) begin
      op(13'(1 << i), 0, 0, '0, 0, 0, 0, 0);
      reg_sel = 0; #0.5;
      chk($sformatf("R2 line %0d position", i), reg_rdata, 32'h1 << pos[i]);
      clear_all();
    end
  endtask

  task automatic t_w1c();
    op(13'h1FFF, 0, 0, '0, 0, 0, 0, 0);
    op('0, 1, 0, 32'hA00A_0000 | 32'h0000_FFFF, 0, 0, 0, 0);
    check_regs("R3 partial clear");
    op('0, 0, 0, '0, 0, 0, 0, 0);
    check_regs("R3 hold");
    clear_all();
  endtask

  task automatic t_set_wins();
    op(13'h0011, 0, 0, '0, 0, 0, 0, 0);
    op(13'h0001, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check_regs("R4 set beats clear");
    clear_all();
  endtask

  task automatic t_mask();
    op('0, 1, 1, 32'hA5A5_1234, 0, 0, 0, 0);
    check_regs("R5 mask load");
    op('0, 1, 1, 32'h0F0F_00C3, 0, 0, 0, 0);
    check_regs("R5 mask replace");
    clear_all();
  endtask

  task automatic t_irq();
    op('0, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    for (int i = 0; i < 13; i++) begin
      op(13'(1 << i), 0, 0, '0, 0, 0, 0, 0);
      chk($sformatf("R6 line %0d lag", i), {19'b0, irq_o}, 32'h0);
      check_irq($sformatf("R6 line %0d map", i));
      op('0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
      check_irq($sformatf("R6 line %0d drop", i));
    end
    op(13'h1FFF, 1, 1, 32'h0C00_0000, 0, 0, 0, 0);
    check_regs("R6 partial mask");
    check_irq("R6 partial mask");
    op('0, 1, 1, 32'h0, 0, 0, 0, 0);
    check_irq("R6 masked off");
    clear_all();
  endtask

  task automatic t_reserved();
    op(13'h1FFF, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    reg_sel = 0; #0.5;
    chk("R7 reserved bits zero", reg_rdata & 32'h0007_FFFF, 32'h0);
    op('0, 1, 0, 32'h0007_FFFF, 0, 0, 0, 0);
    check_regs("R7 reserved write no effect");
    clear_all();
  endtask

  task automatic t_mgmt();
    op('0, 0, 0, '0, 1, 0, 0, 0);
    check_regs("R8 mgmt write");
    clear_all();
  endtask

  task automatic t_txctl();
    op('0, 0, 0, '0, 0, 1, 0, 0);
    check_regs("R9 txctl without go");
    op('0, 0, 0, '0, 0, 1, 1, 0);
    check_regs("R9 txctl with go");
    clear_all();
  endtask

  task automatic t_soft();
    op(13'h1FFF, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check_irq("R10 pre");
    op(13'h1FFF, 1, 1, 32'h1234_5678, 1, 1, 1, 1);
    check_regs("R10 soft reset");
    check_irq("R10 soft reset");
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_w1c();
    t_set_wins();
    t_mask();
    t_irq();
    t_reserved();
    t_mgmt();
    t_txctl();
    t_soft();
    finish_up();
  end
endmodule